// File: doc/BRIEF.md
# 8b/10b Line Encoder with Pass-Through

This block sits in front of a 10:1 serializer in a serial transmitter. Every clock it takes one byte symbol, a control flag marking the byte as a control character, and a flag that forces the running disparity negative for that one symbol. It returns a DC-balanced 10-bit line code. The code is built from a 5b/6b sub-block and a 3b/4b sub-block. Each sub-block picks between its primary code and its complementary code from the running disparity at the point where that sub-block starts. The block keeps the running disparity from symbol to symbol.

A static pass-through control makes the block forward a 10-bit word that is already encoded, unchanged. While pass-through is on, the running disparity is frozen. A control flag on a byte that is not a legal control character raises an error flag on the matching output word. That byte is then encoded as ordinary data.

Top module: `linecode_enc`

## Requirements
- R1: When pass-through is off, one cycle after a byte is presented, `line_code` holds its standard 8b/10b code for the current running disparity. The 6-bit sub-block abcdei sits in bits [9:4], with a at bit 9. The 4-bit sub-block fghj sits in bits [3:0], with f at bit 3. The byte's low five bits select the 6-bit code and its high three bits select the 4-bit code.
- R2: Reset makes the running disparity negative. After each encoded symbol the running disparity becomes positive if the word has more than five ones. It becomes negative if the word has fewer than five ones. It is unchanged if the word has exactly five ones.
- R3: For a data byte whose high three bits are 7, the alternate 4-bit code is used in two cases: the disparity after the 6-bit sub-block is negative and the low five bits are 17, 18 or 20; or that disparity is positive and the low five bits are 11, 13 or 14. The alternate code is 0111 for negative disparity and 1000 for positive. In every other case the primary code is used: 1110 for negative disparity and 0001 for positive.
- R4: With the control flag set, the legal control characters are low five bits 28 with any high three bits, and high three bits 7 with low five bits 23, 27, 29 or 30. These produce the control codes, and `kerr` stays low. For low five bits 28 the 6-bit sub-block is 001111 at negative disparity and 110000 at positive disparity.
- R5: A control flag on any other byte drives `kerr` high on the same output word, and the byte is encoded exactly as data.
- R6: With `sym_force_neg` high, the symbol is encoded as though the running disparity were negative. The new running disparity then follows from that word.
- R7: With `byp_en` high, `line_code` equals `byp_word` one cycle later and `kerr` is low. The running disparity keeps its value for every pass-through cycle.
- R8: While reset is asserted, `line_code` is all zero and `kerr` is low. Every result appears exactly one clock after its inputs.
- R9: Every encoded word (pass-through off) contains four, five or six ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byp_en | input | 1 | Pass-through select: forward `byp_word` unencoded |
| byp_word | input | 10 | Pre-encoded word used in pass-through |
| sym_byte | input | 8 | Byte to encode |
| sym_k | input | 1 | Byte is a control character |
| sym_force_neg | input | 1 | Encode this symbol from negative disparity |
| line_code | output | 10 | Registered 10-bit code word |
| kerr | output | 1 | Illegal control character on this word |

## Verification
The hardest state to reach is the disparity-dependent choice of a code. A given byte must be seen from both disparities, and the alternate 4-bit code needs a specific disparity after the first sub-block. The stimulus sweeps every combination of byte, control flag and force flag in sequence, so the running disparity keeps flipping. A bench model tracks that disparity by counting ones in each expected word. Pass-through is entered once with positive and once with negative disparity, using unbalanced pass-through words. The freeze is then proved by the code chosen for the first symbol encoded afterwards.

// File: rtl/linecode_pkg.sv
package linecode_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;
    localparam int X_W    = 5;
    localparam int Y_W    = BYTE_W - X_W;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = CODE_W - SUB6_W;
    localparam logic [X_W-1:0] X_COMMA = 5'd28;

    typedef struct packed {
        logic              rd_pos;
        logic [CODE_W-1:0] code;
        logic              kerr;
    } enc_state_t;

    // true when the byte names one of the twelve legal control characters
    function automatic logic ctl_legal(input logic [BYTE_W-1:0] b);
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        x = b[X_W-1:0];
        y = b[BYTE_W-1:X_W];
        return (x == X_COMMA) ||
               ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                (x == 5'd29) || (x == 5'd30)));
    endfunction
endpackage

// File: rtl/linecode_enc_6b.sv
module linecode_enc_6b
    import linecode_pkg::*;
(
    input  logic [X_W-1:0]    x_i,
    input  logic              comma_i,
    input  logic              rd_pos_i,
    output logic [SUB6_W-1:0] sub_o,
    output logic              flip_o
);
    logic [SUB6_W-1:0] base;
    logic              alt;

    always_comb begin
        if (comma_i) begin
            base = 6'b001111;
        end else begin
            case (x_i)
                5'd0:  base = 6'b100111;
                5'd1:  base = 6'b011101;
                5'd2:  base = 6'b101101;
                5'd3:  base = 6'b110001;
                5'd4:  base = 6'b110101;
                5'd5:  base = 6'b101001;
                5'd6:  base = 6'b011001;
                5'd7:  base = 6'b111000;
                5'd8:  base = 6'b111001;
                5'd9:  base = 6'b100101;
                5'd10: base = 6'b010101;
                5'd11: base = 6'b110100;
                5'd12: base = 6'b001101;
                5'd13: base = 6'b101100;
                5'd14: base = 6'b011100;
                5'd15: base = 6'b010111;
                5'd16: base = 6'b011011;
                5'd17: base = 6'b100011;
                5'd18: base = 6'b010011;
                5'd19: base = 6'b110010;
                5'd20: base = 6'b001011;
                5'd21: base = 6'b101010;
                5'd22: base = 6'b011010;
                5'd23: base = 6'b111010;
                5'd24: base = 6'b110011;
                5'd25: base = 6'b100110;
                5'd26: base = 6'b010110;
                5'd27: base = 6'b110110;
                5'd28: base = 6'b001110;
                5'd29: base = 6'b101110;
                5'd30: base = 6'b011110;
                default: base = 6'b101011;
            endcase
        end
        flip_o = ($countones(base) != 3);
        alt    = flip_o || (!comma_i && (x_i == 5'd7));
        sub_o  = (rd_pos_i && alt) ? ~base : base;
    end
endmodule

// File: rtl/linecode_enc_4b.sv
module linecode_enc_4b
    import linecode_pkg::*;
(
    input  logic [Y_W-1:0]    y_i,
    input  logic              ctl_i,
    input  logic              a7_i,
    input  logic              rd_pos_i,
    output logic [SUB4_W-1:0] sub_o,
    output logic              flip_o
);
    logic [SUB4_W-1:0] base;
    logic              alt;

    always_comb begin
        if (ctl_i) begin
            case (y_i)
                3'd0: base = 4'b1011;
                3'd1: base = 4'b0110;
                3'd2: base = 4'b1010;
                3'd3: base = 4'b1100;
                3'd4: base = 4'b1101;
                3'd5: base = 4'b0101;
                3'd6: base = 4'b1001;
                default: base = 4'b0111;
            endcase
        end else begin
            case (y_i)
                3'd0: base = 4'b1011;
                3'd1: base = 4'b1001;
                3'd2: base = 4'b0101;
                3'd3: base = 4'b1100;
                3'd4: base = 4'b1101;
                3'd5: base = 4'b1010;
                3'd6: base = 4'b0110;
                default: base = a7_i ? 4'b0111 : 4'b1110;
            endcase
        end
        flip_o = ($countones(base) != 2);
        alt    = ctl_i || (y_i == 3'd0) || (y_i == 3'd3) ||
                 (y_i == 3'd4) || (y_i == 3'd7);
        sub_o  = (rd_pos_i && alt) ? ~base : base;
    end
endmodule

// File: rtl/linecode_enc.sv
module linecode_enc
    import linecode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byp_en,
    input  logic [CODE_W-1:0] byp_word,
    input  logic [BYTE_W-1:0] sym_byte,
    input  logic              sym_k,
    input  logic              sym_force_neg,
    output logic [CODE_W-1:0] line_code,
    output logic              kerr
);
    enc_state_t        st_d, st_q;
    logic [X_W-1:0]    x_fld;
    logic [Y_W-1:0]    y_fld;
    logic              ctl_ok, comma, rd_eff, rd_mid, flip6, flip4, use_a7;
    logic [SUB6_W-1:0] s6;
    logic [SUB4_W-1:0] s4;

    assign x_fld  = sym_byte[X_W-1:0];
    assign y_fld  = sym_byte[BYTE_W-1:X_W];
    assign ctl_ok = sym_k && ctl_legal(sym_byte);
    assign comma  = ctl_ok && (x_fld == X_COMMA);
    assign rd_eff = sym_force_neg ? 1'b0 : st_q.rd_pos;
    assign rd_mid = rd_eff ^ flip6;
    assign use_a7 = rd_mid ? ((x_fld == 5'd11) || (x_fld == 5'd13) || (x_fld == 5'd14))
                           : ((x_fld == 5'd17) || (x_fld == 5'd18) || (x_fld == 5'd20));

    linecode_enc_6b u_enc6 (
        .x_i      (x_fld),
        .comma_i  (comma),
        .rd_pos_i (rd_eff),
        .sub_o    (s6),
        .flip_o   (flip6)
    );

    linecode_enc_4b u_enc4 (
        .y_i      (y_fld),
        .ctl_i    (ctl_ok),
        .a7_i     (use_a7),
        .rd_pos_i (rd_mid),
        .sub_o    (s4),
        .flip_o   (flip4)
    );

    always_comb begin
        st_d = st_q;
        if (byp_en) begin
            st_d.code = byp_word;
            st_d.kerr = 1'b0;
        end else begin
            st_d.code   = {s6, s4};
            st_d.kerr   = sym_k && !ctl_ok;
            st_d.rd_pos = rd_mid ^ flip4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_code = st_q.code;
    assign kerr      = st_q.kerr;
endmodule

// File: rtl/linecode_enc_chk.sv
module linecode_enc_chk
    import linecode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              byp_en,
    input logic [CODE_W-1:0] byp_word,
    input logic [BYTE_W-1:0] sym_byte,
    input logic              sym_k,
    input logic              sym_force_neg,
    input logic [CODE_W-1:0] line_code,
    input logic              kerr
);
    p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byp_en |=> (line_code == $past(byp_word)) && !kerr);

    p_word_weight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_en |=> ($countones(line_code) >= 4) && ($countones(line_code) <= 6));

    p_force_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_en && sym_force_neg) |=> ($countones(line_code) >= 5));

    p_comma_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_en && sym_k && (sym_byte[X_W-1:0] == X_COMMA)) |=>
        ((line_code[9:4] == 6'b001111) || (line_code[9:4] == 6'b110000)) && !kerr);

    p_data_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_k |=> !kerr);
endmodule

bind linecode_enc linecode_enc_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .byp_en        (byp_en),
    .byp_word      (byp_word),
    .sym_byte      (sym_byte),
    .sym_k         (sym_k),
    .sym_force_neg (sym_force_neg),
    .line_code     (line_code),
    .kerr          (kerr)
);

// File: tb/linecode_enc_tb.sv
module linecode_enc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byp_en = 1'b0;
    logic [9:0] byp_word = '0;
    logic [7:0] sym_byte = '0;
    logic       sym_k = 1'b0;
    logic       sym_force_neg = 1'b0;
    logic [9:0] line_code;
    logic       kerr;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    logic m_rd = 1'b0;   // model running disparity, 1 = positive

    always #(CLK_PERIOD/2) clk = ~clk;

    linecode_enc dut_i (
        .clk(clk), .rst_n(rst_n), .byp_en(byp_en), .byp_word(byp_word),
        .sym_byte(sym_byte), .sym_k(sym_k), .sym_force_neg(sym_force_neg),
        .line_code(line_code), .kerr(kerr)
    );

    function automatic logic [5:0] neg6(input logic [4:0] x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                                6'b110101, 6'b101001, 6'b011001, 6'b111000,
                                6'b111001, 6'b100101, 6'b010101, 6'b110100,
                                6'b001101, 6'b101100, 6'b011100, 6'b010111,
                                6'b011011, 6'b100011, 6'b010011, 6'b110010,
                                6'b001011, 6'b101010, 6'b011010, 6'b111010,
                                6'b110011, 6'b100110, 6'b010110, 6'b110110,
                                6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic logic [3:0] neg4(input logic [2:0] y, input logic ctl, input logic a7);
        logic [3:0] td [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                               4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic [3:0] tk [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                               4'b1101, 4'b0101, 4'b1001, 4'b0111};
        if (ctl) return tk[y];
        if (y == 3'd7 && a7) return 4'b0111;
        return td[y];
    endfunction

    function automatic bit legal_k(input logic [7:0] b);
        int x = int'(b[4:0]);
        int y = int'(b[7:5]);
        return (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
    endfunction

    // reference encode: disparity tracked by counting ones
    function automatic logic [10:0] ref_enc(input logic [7:0] b, input bit ctl, input logic rd);
        logic [4:0] x = b[4:0];
        logic [2:0] y = b[7:5];
        logic [5:0] c6;
        logic [3:0] c4;
        logic       rd6, rdn, a7;
        int         n6, n4, nt;
        c6 = (ctl && x == 5'd28) ? 6'b001111 : neg6(x);
        n6 = $countones(c6);
        if (rd && (n6 != 3 || (!(ctl && x == 5'd28) && x == 5'd7))) c6 = ~c6;
        n6 = $countones(c6);
        rd6 = (n6 > 3) ? 1'b1 : (n6 < 3) ? 1'b0 : rd;
        a7 = rd6 ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
        c4 = neg4(y, ctl, a7);
        n4 = $countones(c4);
        if (rd6 && (ctl || n4 != 2 || y == 3'd3)) c4 = ~c4;
        nt = $countones({c6, c4});
        rdn = (nt > 5) ? 1'b1 : (nt < 5) ? 1'b0 : rd;
        return {rdn, c6, c4};
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual kerr/code=%b_%b expected=%b_%b",
                     tag, act[10], act[9:0], exp[10], exp[9:0]);
        end
    endtask

    // drive one symbol and check the word one clock later (sampled at negedge)
    task automatic step(input bit byp, input logic [9:0] w, input logic [7:0] b,
                        input bit k, input bit f);
        logic [10:0] r;
        logic [9:0]  exp_code;
        bit          exp_err;
        string       tag;
        int          ones;
        byp_en = byp; byp_word = w; sym_byte = b; sym_k = k; sym_force_neg = f;
        if (byp) begin
            exp_code = w; exp_err = 1'b0; tag = "R7";
        end else begin
            r = ref_enc(b, k && legal_k(b), f ? 1'b0 : m_rd);
            exp_code = r[9:0];
            exp_err = k && !legal_k(b);
            if (exp_err) tag = "R5";
            else if (k) tag = "R4";
            else if (f) tag = "R6";
            else if (b[7:5] == 3'd7) tag = "R3";
            else tag = m_rd ? "R2" : "R1";
            m_rd = r[10];
        end
        @(negedge clk);
        check(tag, {kerr, line_code}, {exp_err, exp_code});
        if (!byp) begin
            ones = $countones(line_code);
            checks++;
            if (ones < 4 || ones > 6) begin
                failures++;
                $display("FAIL R9: actual ones=%0d expected=4..6", ones);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", {kerr, line_code}, 11'd0);
        sym_k = 1'b1; sym_byte = 8'h00;           // illegal K held in reset
        @(negedge clk);
        check("R8 reset hold", {kerr, line_code}, 11'd0);
        rst_n = 1'b1;
        // R1 R2 R3 R4 R5 R6: full sweep, disparity evolves naturally
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 2; k++)
                for (int b = 0; b < 256; b++)
                    step(1'b0, '0, 8'(b), k[0], f[0]);
        // R3: alternate codes reached from both disparities
        for (int i = 0; i < 2; i++)
            foreach (alt_bytes[j]) step(1'b0, '0, alt_bytes[j], 1'b0, 1'b0);
        // R7: pass-through with positive then negative disparity held
        for (int pass = 0; pass < 2; pass++) begin
            for (int g = 0; g < 4 && (m_rd != pass[0] ? 1'b0 : 1'b1) == 1'b1; g++)
                step(1'b0, '0, 8'h21, 1'b0, 1'b0);
            step(1'b1, 10'h3FF, 8'h00, 1'b1, 1'b0);
            step(1'b1, 10'h000, 8'hFF, 1'b0, 1'b1);
            step(1'b1, 10'h3F0, 8'h1C, 1'b1, 1'b0);
            step(1'b0, '0, 8'h00, 1'b0, 1'b0);    // code choice proves held RD
            step(1'b0, '0, 8'hFC, 1'b1, 1'b0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [7:0] alt_bytes [6] = '{8'hF1, 8'hF2, 8'hF4, 8'hEB, 8'hED, 8'hEE};
endmodule